// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

A tiny fetch, decode and execute engine. It holds an 8-bit accumulator, two 8-bit index registers, an 8-bit status byte and a 16-bit program counter. It drives the address of a byte-wide synchronous memory and takes that memory's read data back. After reset it reads its start address from a fixed little-endian vector. It then runs a four-opcode program: load accumulator immediate, copy accumulator to the first index register, increment that index register, and a stop opcode. Any other opcode stops the core and raises an illegal-opcode flag.

Every memory read takes one wait state. The core drives an address on one edge, the memory registers the read data on the next edge, and the sequencer uses that data on the edge after that. All architectural state comes out on registered ports, so a surrounding system or a bench can watch program progress directly.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, `acc`, `idx_x`, `idx_y` and `pc` become 0, `status` becomes `STATUS_INIT` (default 0x00), and `halted` and `illegal` become 0.
- R2: After reset is released, `pc` is loaded from the 16-bit word at `RESET_VEC` (default 0xFFFC). The byte at `RESET_VEC` is the low half and the byte at `RESET_VEC`+1 is the high half. The load happens on the fourth rising edge with `rst` low.
- R3: `mem_addr` is registered. Read data is expected on `mem_rdata` one cycle after an address is driven, and the core uses it one edge later, so every read costs exactly one wait cycle.
- R4: The first opcode is decoded two edges after the `pc` load. On the decode edge `pc` increases by 1. After 0xAA or 0xE8 the next decode comes two edges later.
- R5: Opcode 0xA9 loads the byte at the incremented `pc` into `acc` two edges after its decode edge. On that same edge `pc` increases by 1 again, and the next decode comes two edges later.
- R6: Opcode 0xAA copies `acc` into `idx_x` on its decode edge.
- R7: Opcode 0xE8 adds 1 to `idx_x` modulo 256 on its decode edge, so 0xFF becomes 0x00.
- R8: On the edge where 0xA9, 0xAA or 0xE8 writes its result, status bit 1 becomes 1 exactly when the result is 0, and status bit 7 becomes bit 7 of the result. All other status bits keep their value.
- R9: Opcode 0x00 sets `halted` on its decode edge, with `pc` incremented past it. From then until the next reset, no output changes.
- R10: Any opcode other than 0xA9, 0xAA, 0xE8 and 0x00 sets both `illegal` and `halted` on its decode edge. The core then stays frozen as in R9.
- R11: No opcode writes `idx_y`, so it keeps its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Registered read address to the memory |
| mem_rdata | input | 8 | Registered read data, one cycle behind the address |
| acc | output | 8 | Accumulator |
| idx_x | output | 8 | First index register |
| idx_y | output | 8 | Second index register |
| status | output | 8 | Status byte; bit 1 is zero, bit 7 is negative |
| pc | output | 16 | Program counter |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
The bench builds the core with `STATUS_INIT` = 0x24 instead of the cleared default. This sets two status bits that no opcode owns, so any instruction that disturbs bits outside 1 and 7 shows up on the port. The reset vector stays at its default, and the bench rewrites the vector bytes to start one program at 0x9000 rather than 0x8000. A behavioural model with per-opcode edge counts is checked against every output on every clock. This checks wait-state timing as well as final values, including a reset issued in the middle of a program.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  // status byte layout
  localparam int SW      = 8;
  localparam int ZF_BIT  = 1;
  localparam int NF_BIT  = 7;

  // supported opcodes
  localparam logic [7:0] OPC_LDA_IMM = 8'hA9;
  localparam logic [7:0] OPC_TAX     = 8'hAA;
  localparam logic [7:0] OPC_INX     = 8'hE8;
  localparam logic [7:0] OPC_BRK     = 8'h00;

  typedef enum logic [2:0] {
    K_LDA,
    K_TAX,
    K_INX,
    K_BRK,
    K_BAD
  } op_kind_e;

  typedef enum logic [3:0] {
    S_VLO_W,
    S_VLO,
    S_VHI_W,
    S_VHI,
    S_OP_W,
    S_DEC,
    S_IMM_W,
    S_IMM,
    S_HALT
  } seq_state_e;

endpackage

// File: rtl/acc_core_dec.sv
module acc_core_dec
  import acc_core_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output op_kind_e      kind
);

  always_comb begin
    unique case (opcode[7:0])
      OPC_LDA_IMM: kind = K_LDA;
      OPC_TAX:     kind = K_TAX;
      OPC_INX:     kind = K_INX;
      OPC_BRK:     kind = K_BRK;
      default:     kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
  import acc_core_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int unsigned RESET_VEC = 32'hFFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rdata,
  input  op_kind_e        kind,
  output logic [2*DW-1:0] mem_addr,
  output logic [2*DW-1:0] pc,
  output logic            halted,
  output logic            illegal,
  output logic            ld_a,
  output logic            do_tax,
  output logic            do_inx
);

  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] VEC_LO = AW'(RESET_VEC);
  localparam logic [AW-1:0] VEC_HI = AW'(RESET_VEC + 1);

  seq_state_e    state;
  logic [DW-1:0] vec_lo;
  logic [AW-1:0] pc_inc;

  assign pc_inc = pc + AW'(1);

  always_comb begin
    ld_a   = (state == S_IMM);
    do_tax = (state == S_DEC) && (kind == K_TAX);
    do_inx = (state == S_DEC) && (kind == K_INX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_VLO_W;
      mem_addr <= VEC_LO;
      pc       <= '0;
      vec_lo   <= '0;
      halted   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      unique case (state)
        S_VLO_W: state <= S_VLO;
        S_VLO: begin
          vec_lo   <= rdata;
          mem_addr <= VEC_HI;
          state    <= S_VHI_W;
        end
        S_VHI_W: state <= S_VHI;
        S_VHI: begin
          pc       <= {rdata, vec_lo};
          mem_addr <= {rdata, vec_lo};
          state    <= S_OP_W;
        end
        S_OP_W: state <= S_DEC;
        S_DEC: begin
          pc <= pc_inc;
          unique case (kind)
            K_LDA: begin
              mem_addr <= pc_inc;
              state    <= S_IMM_W;
            end
            K_TAX, K_INX: begin
              mem_addr <= pc_inc;
              state    <= S_OP_W;
            end
            K_BRK: begin
              halted <= 1'b1;
              state  <= S_HALT;
            end
            default: begin
              halted  <= 1'b1;
              illegal <= 1'b1;
              state   <= S_HALT;
            end
          endcase
        end
        S_IMM_W: state <= S_IMM;
        S_IMM: begin
          pc       <= pc_inc;
          mem_addr <= pc_inc;
          state    <= S_OP_W;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  // R9
  pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc) && $stable(mem_addr));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_OP_W) |=> $stable(mem_addr));

endmodule

// File: rtl/acc_core_regs.sv
module acc_core_regs
  import acc_core_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [7:0]  STATUS_INIT = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_a,
  input  logic [DW-1:0] ld_data,
  input  logic          do_tax,
  input  logic          do_inx,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] idx_x,
  output logic [DW-1:0] idx_y,
  output logic [SW-1:0] status
);

  localparam logic [SW-1:0] FLAG_MASK = SW'((1 << ZF_BIT) | (1 << NF_BIT));

  logic [DW-1:0] x_next;
  assign x_next = idx_x + DW'(1);

  function automatic logic [SW-1:0] set_flags(input logic [SW-1:0] st,
                                              input logic [DW-1:0] res);
    logic [SW-1:0] r;
    r         = st;
    r[ZF_BIT] = (res == '0);
    r[NF_BIT] = res[DW-1];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      idx_x  <= '0;
      idx_y  <= '0;
      status <= STATUS_INIT;
    end else if (ld_a) begin
      acc    <= ld_data;
      status <= set_flags(status, ld_data);
    end else if (do_tax) begin
      idx_x  <= acc;
      status <= set_flags(status, acc);
    end else if (do_inx) begin
      idx_x  <= x_next;
      status <= set_flags(status, x_next);
    end
  end

  // R11
  y_const_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(idx_y));

  // R8
  other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(status & ~FLAG_MASK));

  // R7
  inx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    do_inx |=> idx_x == DW'($past(idx_x) + DW'(1)));

  // R6
  tax_copy_chk: assert property (@(posedge clk) disable iff (rst)
    do_tax |=> idx_x == $past(acc));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int unsigned RESET_VEC   = 32'hFFFC,
  parameter logic [7:0]  STATUS_INIT = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [2*DATA_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [DATA_W-1:0]     acc,
  output logic [DATA_W-1:0]     idx_x,
  output logic [DATA_W-1:0]     idx_y,
  output logic [7:0]            status,
  output logic [2*DATA_W-1:0]   pc,
  output logic                  halted,
  output logic                  illegal
);

  op_kind_e kind;
  logic     ld_a;
  logic     do_tax;
  logic     do_inx;

  acc_core_dec #(.DW(DATA_W)) u_dec (
    .opcode (mem_rdata),
    .kind   (kind)
  );

  acc_core_seq #(.DW(DATA_W), .RESET_VEC(RESET_VEC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rdata    (mem_rdata),
    .kind     (kind),
    .mem_addr (mem_addr),
    .pc       (pc),
    .halted   (halted),
    .illegal  (illegal),
    .ld_a     (ld_a),
    .do_tax   (do_tax),
    .do_inx   (do_inx)
  );

  acc_core_regs #(.DW(DATA_W), .STATUS_INIT(STATUS_INIT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ld_a    (ld_a),
    .ld_data (mem_rdata),
    .do_tax  (do_tax),
    .do_inx  (do_inx),
    .acc     (acc),
    .idx_x   (idx_x),
    .idx_y   (idx_y),
    .status  (status)
  );

  // R9
  strobes_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(ld_a || do_tax || do_inx));

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

  localparam int         CLK_P = 10;
  localparam int         VEC   = 32'hFFFC;
  localparam logic [7:0] ST0   = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  acc, idx_x, idx_y, status;
  logic [15:0] pc;
  logic        halted, illegal;

  logic [7:0]  mem [0:65535];

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  int m_a, m_x, m_y, m_st, m_pc, m_wait, m_act;
  int m_halt, m_ill;
  bit m_valid = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acc_core #(.DATA_W(8), .RESET_VEC(VEC), .STATUS_INIT(ST0)) uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .acc(acc), .idx_x(idx_x), .idx_y(idx_y), .status(status),
    .pc(pc), .halted(halted), .illegal(illegal)
  );

  always @(posedge clk) mem_rdata <= mem[mem_addr];

  task automatic cmp(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  function automatic int flags(int st, int res);
    return (st & ~32'h82) | ((res == 0) ? 2 : 0) | (res & 32'h80);
  endfunction

  // act codes: 0 idle, 1 vector load, 2 decode, 3 immediate
  task automatic model_tick();
    int op;
    if (rst) begin
      m_a = 0; m_x = 0; m_y = 0; m_st = ST0; m_pc = 0;
      m_halt = 0; m_ill = 0; m_act = 1; m_wait = 3; m_valid = 1'b1;
    end else if (m_act != 0) begin
      if (m_wait > 0) m_wait--;
      else begin
        case (m_act)
          1: begin
            m_pc = mem[VEC] | (mem[VEC + 1] << 8);
            m_act = 2; m_wait = 1;
          end
          2: begin
            op = mem[m_pc];
            m_pc = (m_pc + 1) & 32'hFFFF;
            m_wait = 1;
            case (op)
              8'hA9: m_act = 3;
              8'hAA: begin m_x = m_a; m_st = flags(m_st, m_x); end
              8'hE8: begin m_x = (m_x + 1) & 32'hFF; m_st = flags(m_st, m_x); end
              8'h00: begin m_halt = 1; m_act = 0; end
              default: begin m_halt = 1; m_ill = 1; m_act = 0; end
            endcase
          end
          default: begin
            m_a = mem[m_pc];
            m_st = flags(m_st, m_a);
            m_pc = (m_pc + 1) & 32'hFFFF;
            m_act = 2; m_wait = 1;
          end
        endcase
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    model_tick();
    if (m_valid) begin
      cmp("R5", "acc", acc, m_a);
      cmp("R6/R7", "idx_x", idx_x, m_x);
      cmp("R11", "idx_y", idx_y, m_y);
      cmp("R8", "status", status, m_st);
      cmp("R2/R4", "pc", pc, m_pc);
      cmp("R9", "halted", halted, m_halt);
      cmp("R10", "illegal", illegal, m_ill);
    end
  end

  task automatic set_vec(int addr);
    mem[VEC]     = addr[7:0];
    mem[VEC + 1] = addr[15:8];
  endtask

  task automatic start();
    @(negedge clk) rst <= 1'b1;
    repeat (2) @(negedge clk);
    // R1: registers during reset
    cmp("R1", "acc_rst", acc, 0);
    cmp("R1", "x_rst", idx_x, 0);
    cmp("R1", "status_rst", status, ST0);
    cmp("R1", "halted_rst", halted, 0);
    rst <= 1'b0;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    set_vec(16'h8000);

    // T1 load immediate, nonzero positive (R5, R8)
    mem[16'h8000] = 8'hA9; mem[16'h8001] = 8'h05; mem[16'h8002] = 8'h00;
    start();
    run_to_halt();
    cmp("R5", "t1_acc", acc, 8'h05);
    cmp("R8", "t1_status", status, 8'h24);
    cmp("R9", "t1_pc", pc, 16'h8003);

    // T2 load zero sets zero flag (R8)
    mem[16'h8001] = 8'h00;
    start();
    run_to_halt();
    cmp("R8", "t2_status", status, 8'h26);

    // T3 load, transfer, increment (R6, R7)
    mem[16'h8000] = 8'hA9; mem[16'h8001] = 8'hC0; mem[16'h8002] = 8'hAA;
    mem[16'h8003] = 8'hE8; mem[16'h8004] = 8'h00;
    start();
    run_to_halt();
    cmp("R7", "t3_x", idx_x, 8'hC1);
    cmp("R8", "t3_status", status, 8'hA4);

    // T4 increment wraps through zero (R7)
    mem[16'h8001] = 8'hFF; mem[16'h8004] = 8'hE8; mem[16'h8005] = 8'h00;
    start();
    run_to_halt();
    cmp("R7", "t4_x", idx_x, 8'h01);

    // T5 alternate start address and undefined opcode (R2, R10)
    set_vec(16'h9000);
    mem[16'h9000] = 8'hA9; mem[16'h9001] = 8'h80; mem[16'h9002] = 8'h02;
    start();
    run_to_halt();
    cmp("R10", "t5_illegal", illegal, 1);
    cmp("R2", "t5_pc", pc, 16'h9003);
    cmp("R5", "t5_acc", acc, 8'h80);

    // T6 reset mid-program, then full run (R1, R7)
    set_vec(16'h8000);
    for (int i = 0; i < 30; i++) mem[16'h8000 + i] = 8'hE8;
    mem[16'h801E] = 8'h00;
    start();
    repeat (20) @(negedge clk);
    start();
    run_to_halt();
    cmp("R7", "t6_x", idx_x, 8'h1E);

    // T7 frozen after stop (R9)
    repeat (30) @(negedge clk);
    cmp("R9", "t7_pc", pc, 16'h801F);
    cmp("R9", "t7_halted", halted, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule